// File: doc/BRIEF.md
# Banked Supervisor Stack Pointer Selector

This block holds the three physical 32-bit pointers that sit behind the single architectural stack-pointer register: a user pointer, an interrupt pointer and a master pointer. It keeps the supervisor and master bits of the 16-bit status register. From those two bits it picks which pointer the implicit stack-pointer port reads and writes. User mode always gets the user pointer. In supervisor mode the master bit chooses between the master pointer and the interrupt pointer.

A second port pair reaches the interrupt pointer or the master pointer directly, whatever the mode is. Privileged move operations use it to load or inspect the inactive supervisor pointer. An exception-entry hook lets the sequencer report the start of exception processing. On an interrupt entry the master bit is forced clear, so that the stacking which follows goes to the interrupt pointer. Both write ports take a full long word, or a word that is sign-extended to 32 bits.

Top module: `banked_sp_file`

## Requirements
- R1: After reset the supervisor bit is 1, the master bit is 0 and all three pointers hold 0, so the interrupt pointer is active.
- R2: With the supervisor bit 1 and the master bit 0, the active port reads and writes the interrupt pointer.
- R3: With the supervisor bit 1 and the master bit 1, the active port reads and writes the master pointer.
- R4: With the supervisor bit 0, the active port reads and writes the user pointer whatever the master bit holds, and neither supervisor pointer changes.
- R5: A status write loads the supervisor bit from bit 13 and the master bit from bit 12 of `sr_wdata`, ignores all other bits, and shows the new values from the next cycle on.
- R6: An exception entry with `exc_irq`=1 clears the master bit at the next edge. This takes priority over a status write in the same cycle, and the supervisor bit from that status write still applies.
- R7: An exception entry with `exc_irq`=0 leaves the master bit unchanged.
- R8: On either write port, `*_long`=1 stores all 32 bits, and `*_long`=0 stores bits 15:0 sign-extended from bit 15.
- R9: On the explicit ports, select 0 names the interrupt pointer and select 1 names the master pointer. Reads and writes work in every mode, including on the inactive pointer.
- R10: When an active write and an explicit write hit the same pointer in one cycle, the explicit write wins. When they hit different pointers, both take effect.
- R11: A write takes effect at the next edge. The target of an active write is chosen by the mode bits held before that edge, even when a status write in the same cycle changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_we | input | 1 | Status register write strobe |
| sr_wdata | input | 16 | Status register write value (bits 13 and 12 used) |
| exc_valid | input | 1 | Exception entry this cycle |
| exc_irq | input | 1 | The entering exception is an interrupt |
| asp_we | input | 1 | Active stack pointer write strobe |
| asp_long | input | 1 | Active write size: 1 long, 0 word |
| asp_wdata | input | 32 | Active write data |
| asp_rdata | output | 32 | Active stack pointer value |
| xsp_rsel | input | 1 | Explicit read select: 0 interrupt, 1 master |
| xsp_rdata | output | 32 | Explicit read value |
| xsp_we | input | 1 | Explicit write strobe |
| xsp_wsel | input | 1 | Explicit write select: 0 interrupt, 1 master |
| xsp_long | input | 1 | Explicit write size: 1 long, 0 word |
| xsp_wdata | input | 32 | Explicit write data |
| sr_s | output | 1 | Current supervisor bit |
| sr_m | output | 1 | Current master bit |

## Verification
The pointer selection is exercised in all three modes. In each mode, distinct values are written through the active port and then read back through both read ports, so a wrong bank choice shows as a value turning up in the wrong pointer. User mode is tried with the master bit both set and clear, which confirms that the master bit is ignored there. Status writes with every unused bit set check that only bits 13 and 12 are decoded. Interrupt and non-interrupt entries are each applied with the master bit set and clear, and also in the same cycle as a status write. Word writes with bit 15 set and with bit 15 clear check the sign extension, and same-cycle writes through both ports check collisions and write ordering.

// File: rtl/sp_bank_pkg.sv
package sp_bank_pkg;

  typedef enum logic [1:0] {
    SLOT_USER = 2'd0,
    SLOT_INT  = 2'd1,
    SLOT_MST  = 2'd2
  } sp_slot_e;

  localparam int unsigned NUM_SLOTS = 3;

endpackage

// File: rtl/sp_mode_ctrl.sv
module sp_mode_ctrl #(
  parameter int unsigned SR_W  = 16,
  parameter int unsigned S_POS = 13,
  parameter int unsigned M_POS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_we,
  input  logic [SR_W-1:0] sr_wdata,
  input  logic            exc_valid,
  input  logic            exc_irq,
  output logic            s_q,
  output logic            m_q
);

  logic s_d;
  logic m_d;
  logic irq_entry;

  assign irq_entry = exc_valid && exc_irq;

  // Interrupt entry overrides the master bit of a concurrent status write.
  always_comb begin
    s_d = s_q;
    m_d = m_q;
    if (sr_we) begin
      s_d = sr_wdata[S_POS];
      m_d = sr_wdata[M_POS];
    end
    if (irq_entry) begin
      m_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= 1'b1;
      m_q <= 1'b0;
    end else begin
      s_q <= s_d;
      m_q <= m_d;
    end
  end

endmodule

// File: rtl/sp_slot_decode.sv
module sp_slot_decode
  import sp_bank_pkg::*;
(
  input  logic                 s_bit,
  input  logic                 m_bit,
  output sp_slot_e             act_slot,
  output logic [NUM_SLOTS-1:0] act_onehot
);

  always_comb begin
    if (!s_bit) begin
      act_slot = SLOT_USER;
    end else if (m_bit) begin
      act_slot = SLOT_MST;
    end else begin
      act_slot = SLOT_INT;
    end
  end

  always_comb begin
    act_onehot = '0;
    act_onehot[act_slot] = 1'b1;
  end

endmodule

// File: rtl/sp_wdata_fmt.sv
module sp_wdata_fmt #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic              is_long,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] word_ext;

  assign word_ext = {{EXT_W{din[WORD_W-1]}}, din[WORD_W-1:0]};

  always_comb begin
    if (is_long) begin
      dout = din;
    end else begin
      dout = word_ext;
    end
  end

endmodule

// File: rtl/sp_slot_reg.sv
module sp_slot_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_we,
  input  logic [DATA_W-1:0] act_data,
  input  logic              xp_we,
  input  logic [DATA_W-1:0] xp_data,
  output logic [DATA_W-1:0] q
);

  logic              en;
  logic [DATA_W-1:0] d;

  // The explicit port has priority over the active port.
  always_comb begin
    en = act_we || xp_we;
    d  = q;
    if (xp_we) begin
      d = xp_data;
    end else if (act_we) begin
      d = act_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/banked_sp_file.sv
module banked_sp_file
  import sp_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SR_W   = 16,
  parameter int unsigned S_POS  = 13,
  parameter int unsigned M_POS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_we,
  input  logic [SR_W-1:0]   sr_wdata,
  input  logic              exc_valid,
  input  logic              exc_irq,
  input  logic              asp_we,
  input  logic              asp_long,
  input  logic [DATA_W-1:0] asp_wdata,
  output logic [DATA_W-1:0] asp_rdata,
  input  logic              xsp_rsel,
  output logic [DATA_W-1:0] xsp_rdata,
  input  logic              xsp_we,
  input  logic              xsp_wsel,
  input  logic              xsp_long,
  input  logic [DATA_W-1:0] xsp_wdata,
  output logic              sr_s,
  output logic              sr_m
);

  sp_slot_e              act_slot;
  logic [NUM_SLOTS-1:0]  act_onehot;
  logic [NUM_SLOTS-1:0]  act_we_vec;
  logic [NUM_SLOTS-1:0]  xp_we_vec;
  logic [DATA_W-1:0]     asp_fmt;
  logic [DATA_W-1:0]     xsp_fmt;
  logic [DATA_W-1:0]     slot_q [NUM_SLOTS];

  sp_mode_ctrl #(
    .SR_W (SR_W),
    .S_POS(S_POS),
    .M_POS(M_POS)
  ) i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_we    (sr_we),
    .sr_wdata (sr_wdata),
    .exc_valid(exc_valid),
    .exc_irq  (exc_irq),
    .s_q      (sr_s),
    .m_q      (sr_m)
  );

  sp_slot_decode i_dec (
    .s_bit     (sr_s),
    .m_bit     (sr_m),
    .act_slot  (act_slot),
    .act_onehot(act_onehot)
  );

  sp_wdata_fmt #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_asp_fmt (
    .is_long(asp_long),
    .din    (asp_wdata),
    .dout   (asp_fmt)
  );

  sp_wdata_fmt #(.DATA_W(DATA_W), .WORD_W(WORD_W)) i_xsp_fmt (
    .is_long(xsp_long),
    .din    (xsp_wdata),
    .dout   (xsp_fmt)
  );

  always_comb begin
    act_we_vec = asp_we ? act_onehot : '0;
    xp_we_vec  = '0;
    if (xsp_we) begin
      if (xsp_wsel) begin
        xp_we_vec[SLOT_MST] = 1'b1;
      end else begin
        xp_we_vec[SLOT_INT] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    sp_slot_reg #(.DATA_W(DATA_W)) i_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_we  (act_we_vec[g]),
      .act_data(asp_fmt),
      .xp_we   (xp_we_vec[g]),
      .xp_data (xsp_fmt),
      .q       (slot_q[g])
    );
  end

  assign asp_rdata = slot_q[act_slot];
  assign xsp_rdata = xsp_rsel ? slot_q[SLOT_MST] : slot_q[SLOT_INT];

endmodule

// File: rtl/banked_sp_file_chk.sv
module banked_sp_file_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SR_W   = 16,
  parameter int unsigned S_POS  = 13,
  parameter int unsigned M_POS  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_we,
  input logic [SR_W-1:0]   sr_wdata,
  input logic              exc_valid,
  input logic              exc_irq,
  input logic              asp_we,
  input logic              asp_long,
  input logic [DATA_W-1:0] asp_wdata,
  input logic [DATA_W-1:0] asp_rdata,
  input logic              xsp_rsel,
  input logic [DATA_W-1:0] xsp_rdata,
  input logic              xsp_we,
  input logic              xsp_wsel,
  input logic              xsp_long,
  input logic [DATA_W-1:0] xsp_wdata,
  input logic              sr_s,
  input logic              sr_m
);

  localparam int unsigned EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] asp_word_exp;
  logic [DATA_W-1:0] xsp_exp;

  assign asp_word_exp = {{EXT_W{asp_wdata[WORD_W-1]}}, asp_wdata[WORD_W-1:0]};
  assign xsp_exp = xsp_long ? xsp_wdata
                            : {{EXT_W{xsp_wdata[WORD_W-1]}}, xsp_wdata[WORD_W-1:0]};

  // R2
  a_r2_int_active: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_s && !sr_m && !xsp_rsel) |-> (asp_rdata == xsp_rdata));

  // R3
  a_r3_mst_active: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_s && sr_m && xsp_rsel) |-> (asp_rdata == xsp_rdata));

  // R4
  a_r4_user_write: assert property (@(posedge clk) disable iff (!rst_n)
    (asp_we && asp_long && !sr_s && !sr_we) |=> (asp_rdata == $past(asp_wdata)));

  // R6
  a_r6_irq_clears_m: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_irq) |=> !sr_m);

  // R7
  a_r7_nonirq_keeps_m: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !exc_irq && !sr_we) |=> $stable(sr_m));

  // R5
  a_r5_sr_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && !exc_valid) |=> (sr_s == $past(sr_wdata[S_POS]) && sr_m == $past(sr_wdata[M_POS])));

  // R8
  a_r8_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (asp_we && !asp_long && !sr_we && !exc_valid && !xsp_we) |=> (asp_rdata == $past(asp_word_exp)));

  // R10
  a_r10_explicit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (asp_we && xsp_we && sr_s && (sr_m == xsp_wsel) && !sr_we && !exc_valid)
      |=> (asp_rdata == $past(xsp_exp)));

endmodule

bind banked_sp_file banked_sp_file_chk #(
  .DATA_W(DATA_W),
  .WORD_W(WORD_W),
  .SR_W  (SR_W),
  .S_POS (S_POS),
  .M_POS (M_POS)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sr_we    (sr_we),
  .sr_wdata (sr_wdata),
  .exc_valid(exc_valid),
  .exc_irq  (exc_irq),
  .asp_we   (asp_we),
  .asp_long (asp_long),
  .asp_wdata(asp_wdata),
  .asp_rdata(asp_rdata),
  .xsp_rsel (xsp_rsel),
  .xsp_rdata(xsp_rdata),
  .xsp_we   (xsp_we),
  .xsp_wsel (xsp_wsel),
  .xsp_long (xsp_long),
  .xsp_wdata(xsp_wdata),
  .sr_s     (sr_s),
  .sr_m     (sr_m)
);

// File: tb/test_banked_sp_file.sv
module test_banked_sp_file;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        sr_we;
  logic [15:0] sr_wdata;
  logic        exc_valid;
  logic        exc_irq;
  logic        asp_we;
  logic        asp_long;
  logic [31:0] asp_wdata;
  logic [31:0] asp_rdata;
  logic        xsp_rsel;
  logic [31:0] xsp_rdata;
  logic        xsp_we;
  logic        xsp_wsel;
  logic        xsp_long;
  logic [31:0] xsp_wdata;
  logic        sr_s;
  logic        sr_m;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  banked_sp_file i_banked_sp_file (
    .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .exc_valid(exc_valid), .exc_irq(exc_irq), .asp_we(asp_we),
    .asp_long(asp_long), .asp_wdata(asp_wdata), .asp_rdata(asp_rdata),
    .xsp_rsel(xsp_rsel), .xsp_rdata(xsp_rdata), .xsp_we(xsp_we),
    .xsp_wsel(xsp_wsel), .xsp_long(xsp_long), .xsp_wdata(xsp_wdata),
    .sr_s(sr_s), .sr_m(sr_m)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    sr_we = 0; sr_wdata = '0; exc_valid = 0; exc_irq = 0;
    asp_we = 0; asp_long = 1; asp_wdata = '0;
    xsp_we = 0; xsp_wsel = 0; xsp_long = 1; xsp_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic set_sr(input logic [15:0] v);
    sr_we = 1; sr_wdata = v;
    tick();
  endtask

  task automatic asp_wr(input logic lng, input logic [31:0] v);
    asp_we = 1; asp_long = lng; asp_wdata = v;
    tick();
  endtask

  task automatic xsp_wr(input logic sel, input logic lng, input logic [31:0] v);
    xsp_we = 1; xsp_wsel = sel; xsp_long = lng; xsp_wdata = v;
    tick();
  endtask

  task automatic rd_x(input logic sel, output logic [31:0] v);
    xsp_rsel = sel;
    #1;
    v = xsp_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 s", {31'd0, sr_s}, 32'd1);
    chk("R1 m", {31'd0, sr_m}, 32'd0);
    chk("R1 asp", asp_rdata, 32'd0);
    rd_x(0, v); chk("R1 int", v, 32'd0);
    rd_x(1, v); chk("R1 mst", v, 32'd0);
  endtask

  task automatic t_int_active();
    logic [31:0] v;
    asp_wr(1, 32'h1234_5678);
    chk("R2 asp", asp_rdata, 32'h1234_5678);
    rd_x(0, v); chk("R2 int", v, 32'h1234_5678);
    rd_x(1, v); chk("R2 mst untouched", v, 32'd0);
  endtask

  task automatic t_mst_active();
    logic [31:0] v;
    set_sr(16'h3000);
    chk("R5 s", {31'd0, sr_s}, 32'd1);
    chk("R5 m", {31'd0, sr_m}, 32'd1);
    asp_wr(1, 32'hCAFE_0001);
    chk("R3 asp", asp_rdata, 32'hCAFE_0001);
    rd_x(1, v); chk("R3 mst", v, 32'hCAFE_0001);
    rd_x(0, v); chk("R3 int untouched", v, 32'h1234_5678);
  endtask

  task automatic t_user();
    logic [31:0] v;
    set_sr(16'h1000);
    chk("R4 s", {31'd0, sr_s}, 32'd0);
    chk("R4 m", {31'd0, sr_m}, 32'd1);
    asp_wr(1, 32'h0BAD_F00D);
    chk("R4 asp", asp_rdata, 32'h0BAD_F00D);
    rd_x(0, v); chk("R4 int untouched", v, 32'h1234_5678);
    rd_x(1, v); chk("R4 mst untouched", v, 32'hCAFE_0001);
    set_sr(16'hCFFF);
    chk("R5 ignored bits s", {31'd0, sr_s}, 32'd0);
    chk("R5 ignored bits m", {31'd0, sr_m}, 32'd0);
    chk("R4 user m0", asp_rdata, 32'h0BAD_F00D);
    set_sr(16'h2000);
    chk("R5 back to int", asp_rdata, 32'h1234_5678);
  endtask

  task automatic t_word();
    asp_wr(0, 32'h0000_8001);
    chk("R8 neg word", asp_rdata, 32'hFFFF_8001);
    asp_wr(0, 32'hFFFF_7FFE);
    chk("R8 pos word", asp_rdata, 32'h0000_7FFE);
    xsp_wr(1, 0, 32'h0000_F000);
    xsp_rsel = 1; #1;
    chk("R8 explicit word", xsp_rdata, 32'hFFFF_F000);
    xsp_wr(1, 1, 32'hCAFE_0001);
  endtask

  task automatic t_irq();
    set_sr(16'h3000);
    exc_valid = 1; exc_irq = 1;
    tick();
    chk("R6 m cleared", {31'd0, sr_m}, 32'd0);
    chk("R6 int active", asp_rdata, 32'h0000_7FFE);
    exc_valid = 1; exc_irq = 1; sr_we = 1; sr_wdata = 16'h3000;
    tick();
    chk("R6 priority m", {31'd0, sr_m}, 32'd0);
    chk("R6 priority s", {31'd0, sr_s}, 32'd1);
    exc_valid = 1; exc_irq = 1; sr_we = 1; sr_wdata = 16'h1000;
    tick();
    chk("R6 s from write", {31'd0, sr_s}, 32'd0);
    chk("R6 m forced", {31'd0, sr_m}, 32'd0);
  endtask

  task automatic t_nonirq();
    set_sr(16'h3000);
    exc_valid = 1; exc_irq = 0;
    tick();
    chk("R7 m kept 1", {31'd0, sr_m}, 32'd1);
    chk("R7 mst active", asp_rdata, 32'hCAFE_0001);
    set_sr(16'h2000);
    exc_valid = 1; exc_irq = 0;
    tick();
    chk("R7 m kept 0", {31'd0, sr_m}, 32'd0);
  endtask

  task automatic t_explicit();
    logic [31:0] v;
    set_sr(16'h0000);
    xsp_wr(1, 1, 32'h0000_0011);
    xsp_wr(0, 1, 32'h0000_0022);
    rd_x(1, v); chk("R9 mst in user", v, 32'h0000_0011);
    rd_x(0, v); chk("R9 int in user", v, 32'h0000_0022);
    chk("R9 user kept", asp_rdata, 32'h0BAD_F00D);
    set_sr(16'h2000);
    chk("R9 int via active", asp_rdata, 32'h0000_0022);
    xsp_wr(1, 1, 32'h0000_0033);
    rd_x(1, v); chk("R9 inactive mst", v, 32'h0000_0033);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    asp_we = 1; asp_long = 1; asp_wdata = 32'hAAAA_AAAA;
    xsp_we = 1; xsp_wsel = 0; xsp_long = 1; xsp_wdata = 32'hBBBB_BBBB;
    tick();
    chk("R10 explicit wins", asp_rdata, 32'hBBBB_BBBB);
    asp_we = 1; asp_long = 1; asp_wdata = 32'hAAAA_0000;
    xsp_we = 1; xsp_wsel = 1; xsp_long = 1; xsp_wdata = 32'hBBBB_0000;
    tick();
    chk("R10 both int", asp_rdata, 32'hAAAA_0000);
    rd_x(1, v); chk("R10 both mst", v, 32'hBBBB_0000);
  endtask

  task automatic t_order();
    logic [31:0] v;
    sr_we = 1; sr_wdata = 16'h3000;
    asp_we = 1; asp_long = 1; asp_wdata = 32'h5555_1111;
    tick();
    rd_x(0, v); chk("R11 old target int", v, 32'h5555_1111);
    rd_x(1, v); chk("R11 mst untouched", v, 32'hBBBB_0000);
    chk("R11 m now set", {31'd0, sr_m}, 32'd1);
    chk("R11 active mst", asp_rdata, 32'hBBBB_0000);
  endtask

  initial begin
    idle();
    xsp_rsel = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    #1;
    t_reset();
    t_int_active();
    t_mst_active();
    t_user();
    t_word();
    t_irq();
    t_nonirq();
    t_explicit();
    t_collide();
    t_order();
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule